// File: doc/BRIEF.md
# Interrupt presentation controller

This block presents interrupts to a single processor. It holds a 32-bit presentation word, an 8-bit pending priority and an 8-bit inter-processor interrupt (IPI) request register. The presentation word carries the processor's current priority in its top byte and the number of the pending source in its low 24 bits. A source number of zero means nothing is pending. Priorities are numerically inverted: lower values are more favoured, and 0xFF means "none".

A source controller offers at most one interrupt per cycle. The block accepts or rejects each offer one cycle later. When a newly taken interrupt or a software IPI pushes out a pending external interrupt, the block returns that interrupt to its source with a reject notification. The processor side uses a small command port to accept the pending interrupt, signal end of interrupt, write the priority, write the IPI register and poll without side effects. When the processor relaxes its threshold and nothing is pending, the block asks the source side to resend any held interrupts. A level output tells the processor that an interrupt is waiting.

Top module: `intr_present_unit`

## Requirements
- R1: After reset, the presentation word is 0, the pending priority is 0xFF, the IPI register is 0xFF, and `irq_o` and every notification output are low.
- R2: A poll (op 4) or an accept (op 0) raises `rsp_valid` one cycle later. `rsp_word` then holds the presentation word as it was before the command, with the priority in bits 31:24 and the source in bits 23:0. `rsp_ipi` holds the IPI register as it was before the command.
- R3: An offer is rejected (`offer_nak`) if its priority is greater than or equal to the current priority. It is also rejected if a source is pending at a priority less than or equal to the offered one.
- R4: When an offer is taken (`offer_ack`), any pending external source is returned through `rej_valid`/`rej_src`. The offered source and priority are then latched and `irq_o` rises.
- R5: Writing the IPI register (op 3, value in `cmd_data[7:0]`) to a value below the current priority starts an IPI check. The check does nothing if a source is pending at a priority no worse than the IPI register. Otherwise it returns the pending external source, sets the source field to 2, copies the IPI register into the pending priority and raises `irq_o`.
- R6: An accept (op 0) lowers `irq_o`. It loads the current priority from the pending priority, clears the source field and sets the pending priority to 0xFF.
- R7: A priority write (op 2, value in `cmd_data[7:0]`) that lowers the current priority to a value at or below the pending priority does three things: it clears the pending source, sets the pending priority to 0xFF and lowers `irq_o`. If that source was external, it is also returned with a reject.
- R8: A priority write that raises or keeps the current priority while nothing is pending pulses `resend_req` and runs the IPI check when the IPI register is below the new priority.
- R9: An end of interrupt (op 1) loads the current priority from `cmd_data[31:24]` and pulses `eoi_valid` with `eoi_src` set to `cmd_data[23:0]`. If nothing is pending, it also pulses `resend_req` and runs the IPI check when the IPI register is below the new priority.
- R10: A poll changes no state.
- R11: An IPI (source 2) is never returned with a reject.
- R12: A command and an offer in the same cycle are processed with the command first. Every offer receives exactly one of `offer_ack`/`offer_nak` in the following cycle, and neither is raised without an offer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code: 0 accept, 1 end of interrupt, 2 priority write, 3 IPI write, 4 poll |
| cmd_data | input | 32 | Command operand |
| offer_valid | input | 1 | Interrupt offer strobe from the source side |
| offer_src | input | 24 | Offered source number (nonzero, never 2) |
| offer_prio | input | 8 | Offered priority |
| offer_ack | output | 1 | Previous cycle's offer was taken |
| offer_nak | output | 1 | Previous cycle's offer was rejected |
| rej_valid | output | 1 | A displaced external interrupt is returned |
| rej_src | output | 24 | Source number being returned |
| eoi_valid | output | 1 | End-of-interrupt notification |
| eoi_src | output | 24 | Source number ending |
| resend_req | output | 1 | Request that the source side re-offer held interrupts |
| irq_o | output | 1 | Level interrupt to the processor |
| rsp_valid | output | 1 | Poll/accept result valid |
| rsp_word | output | 32 | Presentation word before the command |
| rsp_ipi | output | 8 | IPI register before the command |

## Verification
A processor command and a source offer can land in the same cycle. The important collisions are an offer arriving with an accept, with an IPI write that installs source 2, or with a priority drop that clears the pending source. The bench provokes these in directed steps and at random with `$urandom`. It then checks whether the offer was judged against the state the command left behind. It also checks that at most one source was returned to the source side in that cycle, and that a displaced IPI produced no reject.

// File: rtl/ipu_pkg.sv
// Shared types and helpers for the interrupt presentation controller.
// Assumes: priorities are inverted (lower = more favoured, all-ones = none),
// and source number zero means "nothing pending".
package ipu_pkg;
    localparam int PRIO_W = 8;
    localparam int SRC_W  = 24;
    localparam int WORD_W = PRIO_W + SRC_W;
    localparam int OP_W   = 3;
    localparam logic [SRC_W-1:0]  IPI_SRC   = SRC_W'(2);
    localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

    typedef enum logic [OP_W-1:0] {
        OP_ACCEPT   = 3'd0,
        OP_EOI      = 3'd1,
        OP_SET_PRIO = 3'd2,
        OP_SET_IPI  = 3'd3,
        OP_POLL     = 3'd4
    } op_e;

    // Architectural state of the unit.
    typedef struct packed {
        logic [PRIO_W-1:0] cur_prio;  // processor priority
        logic [SRC_W-1:0]  src;       // pending source, 0 = none
        logic [PRIO_W-1:0] pend_prio; // priority of pending source
        logic [PRIO_W-1:0] ipi_req;   // IPI request priority
        logic              ext;       // pending source has an owner
        logic              irq;       // processor interrupt level
    } pres_t;

    // Result of a state transformation that may return one source.
    typedef struct packed {
        pres_t            st;
        logic             rej;
        logic [SRC_W-1:0] rej_src;
    } step_t;

    // IPI check: install the IPI unless something better is pending.
    function automatic step_t ipi_check(input pres_t s);
        step_t r;
        r.st      = s;
        r.rej     = 1'b0;
        r.rej_src = '0;
        if (!((s.src != '0) && (s.pend_prio <= s.ipi_req))) begin
            r.rej       = (s.src != '0) && s.ext;
            r.rej_src   = s.src;
            r.st.src       = IPI_SRC;
            r.st.pend_prio = s.ipi_req;
            r.st.ext       = 1'b0;
            r.st.irq       = 1'b1;
        end
        return r;
    endfunction
endpackage

// File: rtl/ipu_cmd_stage.sv
// Applies one processor command to the current state (combinational).
// Assumes: at most one command per cycle; unknown op codes have no effect.
// Produces the post-command state that the offer stage then sees.
module ipu_cmd_stage
    import ipu_pkg::*;
(
    input  pres_t               cur,
    input  logic                cmd_valid,
    input  logic [OP_W-1:0]     cmd_op,
    input  logic [WORD_W-1:0]   cmd_data,
    output pres_t               nxt,
    output logic                rej,
    output logic [SRC_W-1:0]    rej_src,
    output logic                eoi,
    output logic [SRC_W-1:0]    eoi_src,
    output logic                resend,
    output logic                rsp_v,
    output logic [WORD_W-1:0]   rsp_word,
    output logic [PRIO_W-1:0]   rsp_ipi
);
    logic [PRIO_W-1:0] new_prio;
    logic              do_resend;
    step_t             chk;

    assign new_prio = cmd_data[PRIO_W-1:0];

    // Decode the command and compute its state change and notifications.
    always_comb begin
        nxt       = cur;
        rej       = 1'b0;
        rej_src   = '0;
        eoi       = 1'b0;
        eoi_src   = '0;
        resend    = 1'b0;
        rsp_v     = 1'b0;
        rsp_word  = {cur.cur_prio, cur.src};
        rsp_ipi   = cur.ipi_req;
        do_resend = 1'b0;
        chk       = '0;
        if (cmd_valid) begin
            case (op_e'(cmd_op))
                OP_ACCEPT: begin
                    rsp_v         = 1'b1;
                    nxt.cur_prio  = cur.pend_prio;
                    nxt.src       = '0;
                    nxt.pend_prio = PRIO_NONE;
                    nxt.ext       = 1'b0;
                    nxt.irq       = 1'b0;
                end
                OP_POLL: rsp_v = 1'b1;
                OP_SET_IPI: begin
                    nxt.ipi_req = new_prio;
                    if (new_prio < cur.cur_prio) begin
                        chk     = ipi_check(nxt);
                        nxt     = chk.st;
                        rej     = chk.rej;
                        rej_src = chk.rej_src;
                    end
                end
                OP_SET_PRIO: begin
                    nxt.cur_prio = new_prio;
                    if (new_prio < cur.cur_prio) begin
                        if ((cur.src != '0) && (new_prio <= cur.pend_prio)) begin
                            rej           = cur.ext;
                            rej_src       = cur.src;
                            nxt.src       = '0;
                            nxt.pend_prio = PRIO_NONE;
                            nxt.ext       = 1'b0;
                            nxt.irq       = 1'b0;
                        end
                    end else if (cur.src == '0) begin
                        do_resend = 1'b1;
                    end
                end
                OP_EOI: begin
                    nxt.cur_prio = cmd_data[WORD_W-1:SRC_W];
                    eoi          = 1'b1;
                    eoi_src      = cmd_data[SRC_W-1:0];
                    do_resend    = (cur.src == '0);
                end
                default: ;
            endcase
            if (do_resend) begin
                resend = 1'b1;
                if (nxt.ipi_req < nxt.cur_prio) begin
                    chk     = ipi_check(nxt);
                    nxt     = chk.st;
                    rej     = chk.rej;
                    rej_src = chk.rej_src;
                end
            end
        end
    end
endmodule

// File: rtl/ipu_offer_stage.sv
// Judges one source offer against the post-command state (combinational).
// Assumes: offered source numbers are nonzero and never the IPI number.
module ipu_offer_stage
    import ipu_pkg::*;
(
    input  pres_t               mid,
    input  logic                offer_valid,
    input  logic [SRC_W-1:0]    offer_src,
    input  logic [PRIO_W-1:0]   offer_prio,
    output pres_t               nxt,
    output logic                take,
    output logic                drop,
    output logic                rej,
    output logic [SRC_W-1:0]    rej_src
);
    logic busy;

    assign busy = (mid.src != '0);

    // Accept or reject the offer; a taken offer displaces a pending source.
    always_comb begin
        nxt     = mid;
        take    = 1'b0;
        drop    = 1'b0;
        rej     = 1'b0;
        rej_src = '0;
        if (offer_valid) begin
            if ((offer_prio >= mid.cur_prio) || (busy && (mid.pend_prio <= offer_prio))) begin
                drop = 1'b1;
            end else begin
                take          = 1'b1;
                rej           = busy && mid.ext;
                rej_src       = mid.src;
                nxt.src       = offer_src;
                nxt.pend_prio = offer_prio;
                nxt.ext       = 1'b1;
                nxt.irq       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/intr_present_unit.sv
// Per-processor interrupt presentation unit: holds the state register and
// registers every notification one cycle after the command/offer that caused it.
// Assumes: command applied before offer within a cycle; sources never use number 2.
module intr_present_unit
    import ipu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [OP_W-1:0]     cmd_op,
    input  logic [WORD_W-1:0]   cmd_data,
    input  logic                offer_valid,
    input  logic [SRC_W-1:0]    offer_src,
    input  logic [PRIO_W-1:0]   offer_prio,
    output logic                offer_ack,
    output logic                offer_nak,
    output logic                rej_valid,
    output logic [SRC_W-1:0]    rej_src,
    output logic                eoi_valid,
    output logic [SRC_W-1:0]    eoi_src,
    output logic                resend_req,
    output logic                irq_o,
    output logic                rsp_valid,
    output logic [WORD_W-1:0]   rsp_word,
    output logic [PRIO_W-1:0]   rsp_ipi
);
    pres_t             st_q, mid, fin;
    logic              c_rej, c_eoi, c_res, c_rsp;
    logic [SRC_W-1:0]  c_rej_src, c_eoi_src;
    logic [WORD_W-1:0] c_word;
    logic [PRIO_W-1:0] c_ipi;
    logic              o_take, o_drop, o_rej;
    logic [SRC_W-1:0]  o_rej_src;

    ipu_cmd_stage u_cmd (
        .cur(st_q), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .nxt(mid), .rej(c_rej), .rej_src(c_rej_src), .eoi(c_eoi), .eoi_src(c_eoi_src),
        .resend(c_res), .rsp_v(c_rsp), .rsp_word(c_word), .rsp_ipi(c_ipi)
    );

    ipu_offer_stage u_offer (
        .mid(mid), .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
        .nxt(fin), .take(o_take), .drop(o_drop), .rej(o_rej), .rej_src(o_rej_src)
    );

    // State register with the architectural reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cur_prio  <= '0;
            st_q.src       <= '0;
            st_q.pend_prio <= PRIO_NONE;
            st_q.ipi_req   <= PRIO_NONE;
            st_q.ext       <= 1'b0;
            st_q.irq       <= 1'b0;
        end else begin
            st_q <= fin;
        end
    end

    // Registered notifications and command responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offer_ack  <= 1'b0;
            offer_nak  <= 1'b0;
            rej_valid  <= 1'b0;
            rej_src    <= '0;
            eoi_valid  <= 1'b0;
            eoi_src    <= '0;
            resend_req <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_word   <= '0;
            rsp_ipi    <= '0;
        end else begin
            offer_ack  <= o_take;
            offer_nak  <= o_drop;
            rej_valid  <= c_rej | o_rej;
            rej_src    <= c_rej ? c_rej_src : (o_rej ? o_rej_src : '0);
            eoi_valid  <= c_eoi;
            eoi_src    <= c_eoi_src;
            resend_req <= c_res;
            rsp_valid  <= c_rsp;
            rsp_word   <= c_word;
            rsp_ipi    <= c_ipi;
        end
    end

    assign irq_o = st_q.irq;

    AST_IRQ_TRACKS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (st_q.src != '0)); // R5
    AST_OFFER_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |=> (offer_ack != offer_nak)); // R12
    AST_NO_SPURIOUS_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        !offer_valid |=> (!offer_ack && !offer_nak)); // R12
    AST_SINGLE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        !(c_rej && o_rej)); // R4
    AST_TAKE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        o_take |=> irq_o); // R4
    AST_IPI_NEVER_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid |-> (rej_src != IPI_SRC)); // R11
    AST_POLL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_POLL && !offer_valid) |=> $stable(st_q)); // R10
    AST_ACCEPT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ACCEPT && !offer_valid) |=> !irq_o); // R6
endmodule

// File: tb/test_intr_present_unit.sv
`timescale 1ns/1ps
module test_intr_present_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [31:0] cmd_data = '0;
    logic        offer_valid = 1'b0;
    logic [23:0] offer_src = '0;
    logic [7:0]  offer_prio = '0;
    logic        offer_ack, offer_nak, rej_valid, eoi_valid, resend_req, irq_o, rsp_valid;
    logic [23:0] rej_src, eoi_src;
    logic [31:0] rsp_word;
    logic [7:0]  rsp_ipi;

    intr_present_unit i_intr_present_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
        .offer_ack(offer_ack), .offer_nak(offer_nak), .rej_valid(rej_valid), .rej_src(rej_src),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_req(resend_req), .irq_o(irq_o),
        .rsp_valid(rsp_valid), .rsp_word(rsp_word), .rsp_ipi(rsp_ipi)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model state and expected outputs.
    logic [7:0]  m_cur, m_pend, m_ipi;
    logic [23:0] m_src;
    logic        m_ext, m_irq;
    logic        e_ack, e_nak, e_rej, e_eoi, e_res, e_rv;
    logic [23:0] e_rsrc, e_esrc;
    logic [31:0] e_word;
    logic [7:0]  e_ripi;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_ipi();
        if (!((m_src != 0) && (m_pend <= m_ipi))) begin
            if ((m_src != 0) && m_ext) begin e_rej = 1; e_rsrc = m_src; end
            m_src = 24'd2; m_pend = m_ipi; m_ext = 0; m_irq = 1;
        end
    endtask

    task automatic model_step(input bit cv, input logic [2:0] op, input logic [31:0] d,
                              input bit ov, input logic [23:0] s, input logic [7:0] p);
        logic [7:0] oc;
        bit rs;
        rs = 0;
        e_ack = 0; e_nak = 0; e_rej = 0; e_eoi = 0; e_res = 0; e_rv = 0;
        e_rsrc = 0; e_esrc = 0;
        e_word = {m_cur, m_src}; e_ripi = m_ipi;
        if (cv) begin
            case (op)
                3'd0: begin e_rv = 1; m_cur = m_pend; m_src = 0; m_pend = 8'hFF; m_ext = 0; m_irq = 0; end
                3'd1: begin m_cur = d[31:24]; e_eoi = 1; e_esrc = d[23:0]; rs = (m_src == 0); end
                3'd2: begin
                    oc = m_cur; m_cur = d[7:0];
                    if (d[7:0] < oc) begin
                        if ((m_src != 0) && (d[7:0] <= m_pend)) begin
                            e_rej = m_ext; e_rsrc = m_src;
                            m_src = 0; m_pend = 8'hFF; m_ext = 0; m_irq = 0;
                        end
                    end else if (m_src == 0) rs = 1;
                end
                3'd3: begin m_ipi = d[7:0]; if (m_ipi < m_cur) model_ipi(); end
                3'd4: e_rv = 1;
                default: ;
            endcase
            if (rs) begin e_res = 1; if (m_ipi < m_cur) model_ipi(); end
        end
        if (ov) begin
            if ((p >= m_cur) || ((m_src != 0) && (m_pend <= p))) e_nak = 1;
            else begin
                e_ack = 1;
                if ((m_src != 0) && m_ext) begin e_rej = 1; e_rsrc = m_src; end
                m_src = s; m_pend = p; m_ext = 1; m_irq = 1;
            end
        end
    endtask

    // Drive one cycle of stimulus and compare every output after the edge.
    task automatic step(input bit cv, input logic [2:0] op, input logic [31:0] d,
                        input bit ov, input logic [23:0] s, input logic [7:0] p);
        cmd_valid = cv; cmd_op = op; cmd_data = d;
        offer_valid = ov; offer_src = s; offer_prio = p;
        model_step(cv, op, d, ov, s, p);
        @(posedge clk); #1;
        cmd_valid = 0; offer_valid = 0;
        chk(offer_ack == e_ack, "R3/R12 offer_ack", 32'(offer_ack), 32'(e_ack));
        chk(offer_nak == e_nak, "R3/R12 offer_nak", 32'(offer_nak), 32'(e_nak));
        chk(rej_valid == e_rej, "R4 rej_valid", 32'(rej_valid), 32'(e_rej));
        if (e_rej) chk(rej_src == e_rsrc, "R4 rej_src", 32'(rej_src), 32'(e_rsrc));
        chk(eoi_valid == e_eoi, "R9 eoi_valid", 32'(eoi_valid), 32'(e_eoi));
        if (e_eoi) chk(eoi_src == e_esrc, "R9 eoi_src", 32'(eoi_src), 32'(e_esrc));
        chk(resend_req == e_res, "R8 resend_req", 32'(resend_req), 32'(e_res));
        chk(irq_o == m_irq, "R5 irq_o", 32'(irq_o), 32'(m_irq));
        chk(rsp_valid == e_rv, "R2 rsp_valid", 32'(rsp_valid), 32'(e_rv));
        if (e_rv) begin
            chk(rsp_word == e_word, "R2 rsp_word", rsp_word, e_word);
            chk(rsp_ipi == e_ripi, "R2 rsp_ipi", 32'(rsp_ipi), 32'(e_ripi));
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_cur = 0; m_src = 0; m_pend = 8'hFF; m_ipi = 8'hFF; m_ext = 0; m_irq = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state seen at the ports.
        chk(!irq_o && !offer_ack && !rej_valid && !resend_req, "R1 outputs idle", 32'(irq_o), 0);
        step(1, 3'd4, 0, 0, 0, 0);
        chk(rsp_word == 0 && rsp_ipi == 8'hFF, "R1 reset word/ipi", {rsp_word[31:8], rsp_ipi}, 32'hFF);
        step(0, 0, 0, 1, 24'h40, 8'd5);              // R3: priority 0 blocks everything
        chk(offer_nak, "R3 blocked by priority 0", 32'(offer_nak), 1);
        step(1, 3'd2, 32'hFF, 0, 0, 0);              // R8: raise with nothing pending
        chk(resend_req, "R8 resend on raise", 32'(resend_req), 1);
        step(0, 0, 0, 1, 24'h40, 8'd10);             // R4: taken
        step(0, 0, 0, 1, 24'h41, 8'd10);             // R3: equal to pending
        chk(offer_nak, "R3 equal pending rejected", 32'(offer_nak), 1);
        step(0, 0, 0, 1, 24'h42, 8'd3);              // R4: displaces 0x40
        chk(rej_valid && rej_src == 24'h40, "R4 displaced source", 32'(rej_src), 32'h40);
        step(1, 3'd3, 32'd1, 0, 0, 0);               // R5: IPI displaces 0x42
        chk(rej_src == 24'h42 && irq_o, "R5 IPI displaces source", 32'(rej_src), 32'h42);
        step(1, 3'd4, 0, 1, 24'h43, 8'd0);           // R12/R11: poll + offer over IPI
        chk(rsp_word == 32'hFF000002 && !rej_valid, "R11 IPI dropped silently", rsp_word, 32'hFF000002);
        step(1, 3'd4, 0, 0, 0, 0);                   // R10: two polls agree
        step(1, 3'd4, 0, 0, 0, 0);
        chk(rsp_word == 32'hFF000043, "R10 poll unchanged", rsp_word, 32'hFF000043);
        step(1, 3'd0, 0, 0, 0, 0);                   // R6: accept
        chk(!irq_o && rsp_word == 32'hFF000043, "R6 accept", rsp_word, 32'hFF000043);
        step(1, 3'd1, 32'hFF000043, 0, 0, 0);        // R9: EOI, resend, IPI raised
        chk(eoi_src == 24'h43 && resend_req && irq_o, "R9 eoi resend ipi", 32'(eoi_src), 32'h43);
        step(1, 3'd2, 32'd0, 0, 0, 0);               // R7: drop below pending IPI
        chk(!irq_o && !rej_valid, "R7 priority drop clears IPI", 32'(irq_o), 0);
        step(1, 3'd2, 32'hFF, 0, 0, 0);
        step(1, 3'd0, 0, 1, 24'h50, 8'd7);           // R12: accept IPI then offer
        step(1, 3'd2, 32'h04, 1, 24'h51, 8'd2);      // R12: priority drop + offer
        for (int i = 0; i < 4000; i++) begin
            bit cv, ov;
            logic [2:0] op;
            logic [31:0] d;
            cv = ($urandom % 3) != 0;
            op = 3'($urandom % 5);
            d = (op == 3'd1) ? {8'($urandom), 24'd16 + 24'($urandom % 200)} : 32'($urandom % 256);
            if (op == 3'd2 && ($urandom % 2)) d = 32'hFF;
            ov = ($urandom % 2) != 0;
            step(cv, op, d, ov, 24'd16 + 24'($urandom % 200), 8'($urandom));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule